// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and a 128K x 8 asynchronous static RAM. It takes one read or one write per request and turns it into a timed sequence on the memory's address, data and strobe pins. Each timing minimum is given in nanoseconds as a parameter. The block converts each minimum to clock cycles by rounding up, and a down-counter holds each phase for that number of cycles. The memory has two chip selects, one active-low and one active-high. Both are driven inactive whenever no access is running.

A host issues a request by raising `host_req` together with the address, the direction and the write data, while `host_ready` is high. Read data returns in `host_rdata`, qualified by a one-cycle `host_rvalid` pulse.

A level `stby_req` input puts the memory into data-retention standby, with both selects inactive. When `stby_req` falls, the host is kept waiting for one full read-cycle time before the next access.

With the default 10 ns clock the phase lengths are as follows:

| Phase | Cycles |
|-------|--------|
| Read | 7 |
| Write strobe low | 6 |
| Write recovery | 1 |
| Bus turnaround after a read | 3 |
| Standby recovery | 7 |

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and on release, the outputs are idle: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `host_rvalid`=0. `host_ready`=1 unless `stby_req` is high.
- R2: A request is taken only at a rising edge where `host_req` and `host_ready` are both high. `host_ready` stays low from that edge until the access, including any turnaround, has ended. A request raised while `host_ready` is low has no effect.
- R3: A read holds the memory selected (`mem_ce_n`=0, `mem_ce`=1) with `mem_oe_n`=0, `mem_we_n`=1, `mem_dq_oe`=0 and a stable address. This phase lasts the read-cycle count (7 cycles by default).
- R4: The sample on `mem_dq_in` at the rising edge that ends the last read cycle is stored in `host_rdata`. `host_rvalid` is high for exactly the one following cycle.
- R5: A write holds `mem_we_n`=0 with `mem_oe_n`=1, the memory selected and `mem_dq_oe`=1 driving the write data. This phase lasts the longest of the write-pulse, address-to-end and data-to-end counts (6 cycles by default). A recovery phase follows in which `mem_we_n`=1 while select and data are held, so that the whole write spans the write-cycle count (7 cycles by default).
- R6: While selected, `mem_we_n` and `mem_oe_n` are never both low. The controller never drives the data bus while `mem_oe_n` is low.
- R7: After each read, the memory is deselected with `mem_oe_n`=1 for the turnaround count (3 cycles by default) before `host_ready` returns. A read therefore keeps `host_ready` low for 10 cycles.
- R8: While `stby_req` is high and no access is running, both selects are inactive (`mem_ce_n`=1, `mem_ce`=0) and `host_ready` is low. An access already running completes first, and requests made during standby are ignored.
- R9: After `stby_req` falls, `host_ready` stays low through the standby recovery count (7 cycles by default). It rises on the 8th rising edge counted from the fall.
- R10: Between accesses both selects are inactive, the strobes are high and `mem_addr` keeps the last accepted address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Access address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller can take a request |
| host_rdata | output | 8 | Captured read data |
| host_rvalid | output | 1 | One-cycle pulse, `host_rdata` is new |
| stby_req | input | 1 | Level request for retention standby |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Value for the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 8 | Data bus as seen by the controller |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
On every clock the embedded assertions check four things:
- the write strobe and output enable never overlap while selected, and the data bus is never driven against an enabled memory output;
- every write strobe lasts at least its cycle count;
- `host_ready` is only ever high while the memory is idle and deselected;
- `host_rvalid` is a single-cycle pulse, and standby keeps both selects inactive.

Other behaviours can only be shown by the bench's scenarios against a memory model that checks timing:
- the read data returned for each address, including the boundary addresses;
- the exact busy length of reads and writes;
- a request being ignored while busy or in standby;
- the turnaround gap before a write that follows a read;
- the recovery delay after standby.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM access controller.
// Assumes all timing inputs are positive nanosecond values.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WR,
        ST_WREC,
        ST_RET,
        ST_RECOV
    } ctrl_state_t;

    // Internal active-high view of the memory strobes.
    typedef struct packed {
        logic sel;
        logic we;
        logic oe;
        logic drive;
    } strobe_t;

    // Rounds a nanosecond minimum up to whole clock periods.
    function automatic int cycles_for(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe pattern that belongs to each controller state.
    function automatic strobe_t strobes_for(input ctrl_state_t s);
        strobe_t r;
        r = '0;
        case (s)
            ST_RD:   begin r.sel = 1'b1; r.oe = 1'b1; end
            ST_WR:   begin r.sel = 1'b1; r.we = 1'b1; r.drive = 1'b1; end
            ST_WREC: begin r.sel = 1'b1; r.drive = 1'b1; end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that holds a controller phase for a loaded number of cycles.
// Loading N makes `last` high in the N-th cycle after the load edge.
// Assumes a loaded count is never zero.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Load a new phase length, or count the current phase down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));

    // R3: a zero-length phase would never end
    timer_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_data_path.sv
// Address, write-data and read-data registers of the controller.
// Assumes `accept` and `capture` are single-cycle strobes from the sequencer.
module sram_data_path #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);

    // Latch address and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= host_addr;
            mem_dq_out <= host_wdata;
        end
    end

    // Sample the bus at the end of the read phase and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= capture;
            if (capture)
                host_rdata <= mem_dq_in;
        end
    end

    // R4
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(mem_addr));

endmodule

// File: rtl/sram_strobe_ctrl.sv
// Top of the asynchronous SRAM access controller.
// Sequences reads, strobe-controlled writes, the post-read bus turnaround,
// and retention standby with its recovery delay. All strobes are registered,
// so they change only on clock edges and never glitch.
// Assumes the host keeps request fields stable while host_req is high.
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_WC_NS       = 70,
    parameter int T_WP_NS       = 50,
    parameter int T_AW_NS       = 55,
    parameter int T_DW_NS       = 45,
    parameter int T_HZ_NS       = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              stby_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    localparam int RD_CYC  = max2(cycles_for(T_RC_NS, CLK_PERIOD_NS),
                                  cycles_for(T_AA_NS, CLK_PERIOD_NS));
    localparam int WC_CYC  = cycles_for(T_WC_NS, CLK_PERIOD_NS);
    localparam int WP_CYC  = max2(cycles_for(T_WP_NS, CLK_PERIOD_NS),
                                  max2(cycles_for(T_AW_NS, CLK_PERIOD_NS),
                                       cycles_for(T_DW_NS, CLK_PERIOD_NS)));
    localparam int REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int TA_CYC  = max2(1, cycles_for(T_HZ_NS, CLK_PERIOD_NS));
    localparam int RC_CYC  = RD_CYC;
    localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(REC_CYC, TA_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctrl_state_t      st_q, st_d;
    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, capture;
    strobe_t          strb_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .capture     (capture),
        .mem_dq_in   (mem_dq_in),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    assign host_ready = (st_q == ST_IDLE) && !stby_req;

    // Next-state decode and phase-length selection.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (stby_req) begin
                    st_d = ST_RET;
                end else if (host_req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (host_we) begin
                        st_d    = ST_WR;
                        tmr_val = CNT_W'(WP_CYC);
                    end else begin
                        st_d    = ST_RD;
                        tmr_val = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_RD: if (tmr_last) begin
                capture  = 1'b1;
                st_d     = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(TA_CYC);
            end
            ST_TURN: if (tmr_last) st_d = ST_IDLE;
            ST_WR: if (tmr_last) begin
                st_d     = ST_WREC;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_CYC);
            end
            ST_WREC: if (tmr_last) st_d = ST_IDLE;
            ST_RET: if (!stby_req) begin
                st_d     = ST_RECOV;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RC_CYC);
            end
            ST_RECOV: if (tmr_last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Strobe register, loaded with the pattern of the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= '0;
        else        strb_q <= strobes_for(st_d);
    end

    assign mem_ce_n  = !strb_q.sel;
    assign mem_ce    = strb_q.sel;
    assign mem_we_n  = !strb_q.we;
    assign mem_oe_n  = !strb_q.oe;
    assign mem_dq_oe = strb_q.drive;

    // Assertion support: length of the current write-strobe low run.
    logic [CNT_W:0] we_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                we_low_run <= '0;
        else if (!mem_we_n)        we_low_run <= (&we_low_run) ? we_low_run : we_low_run + 1'b1;
        else                       we_low_run <= '0;
    end

    // R6
    no_we_oe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && mem_ce) |-> (mem_we_n || mem_oe_n));

    // R6
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5
    we_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_run >= (CNT_W+1)'(WP_CYC)));

    // R2
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R8
    retention_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RET) |-> (mem_ce_n && !mem_ce));

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
// Scoreboard bench for sram_strobe_ctrl, with a timing-checking memory model.
module sram_strobe_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RD_N = 7;
    localparam int WP_N = 6;
    localparam int TA_N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, stby_req = 1'b0;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid, mem_dq_oe;
    logic [7:0]  host_rdata, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    logic [7:0] shadow [int];
    logic [7:0] cells [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_strobe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .stby_req(stby_req),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Memory model: stores data, returns it after a full read time, flags timing faults.
    int model_viol = 0;
    int we_run = 0, addr_run = 0, dq_run = 0, rd_run = 0, since_rd = 255;
    logic prev_we_low = 1'b0;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;

    task automatic viol(input string what, input int act, input int exp);
        model_viol++;
        failures++;
        $display("FAIL R6 model %s actual=%0d expected=%0d", what, act, exp);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic sel = !mem_ce_n && mem_ce;
            automatic bit   rd_now = sel && !mem_oe_n && mem_we_n;
            if (sel && !mem_we_n && !mem_oe_n) viol("we/oe overlap", 1, 0);
            if (mem_dq_oe && !mem_oe_n) viol("bus clash", 1, 0);
            // write end: strobe rose while still selected
            if (prev_we_low && mem_we_n && sel) begin
                if (we_run < WP_N)   viol("write pulse", we_run, WP_N);
                if (addr_run < WP_N) viol("address to end", addr_run, WP_N);
                if (dq_run < 5)      viol("data to end", dq_run, 5);
                cells[int'(mem_addr)] = mem_dq_out;
            end
            if (rd_run > 0 && !rd_now && rd_run < RD_N) viol("read length", rd_run, RD_N);
            we_run   = (sel && !mem_we_n) ? we_run + 1 : 0;
            addr_run = (sel && mem_addr == prev_addr) ? addr_run + 1 : (sel ? 1 : 0);
            dq_run   = (mem_dq_oe && mem_dq_out == prev_dq) ? dq_run + 1 : (mem_dq_oe ? 1 : 0);
            rd_run   = rd_now ? ((mem_addr == prev_addr) ? rd_run + 1 : 1) : 0;
            since_rd = rd_now ? 0 : ((since_rd < 255) ? since_rd + 1 : 255);
            if (mem_dq_oe && since_rd <= TA_N) viol("turnaround", since_rd, TA_N + 1);
            mem_dq_in = (rd_run >= RD_N)
                      ? (cells.exists(int'(mem_addr)) ? cells[int'(mem_addr)] : 8'h00)
                      : 8'hEE;
            prev_we_low = sel && !mem_we_n;
            prev_addr   = mem_addr;
            prev_dq     = mem_dq_out;
        end
    end

    // Monitor: pop the expected read value for every valid pulse (R4).
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected rvalid", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                chk(host_rdata == e, "R4", "read data", host_rdata, e);
            end
        end
    end

    // Driver: one access, returning busy length and strobe-low cycle counts.
    task automatic access(input bit we, input logic [16:0] a, input logic [7:0] d,
                          output int n_busy, output int n_oe, output int n_we);
        while (!host_ready) @(negedge clk);
        if (!we) exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        else     shadow[int'(a)] = d;
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        n_busy = 0; n_oe = 0; n_we = 0;
        while (!host_ready) begin
            n_busy++;
            if (!mem_oe_n) n_oe++;
            if (!mem_we_n) n_we++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int nb, no, nw;
        repeat (3) @(negedge clk);
        // R1: idle outputs while held in reset
        chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rvalid,
            "R1", "strobes in reset", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready == 1'b1, "R1", "ready after reset", host_ready, 1);
        chk(mem_ce_n && !mem_ce, "R1", "deselected after reset", mem_ce_n, 1);

        // R5: write timing, boundary addresses included
        access(1'b1, 17'h00000, 8'hA5, nb, no, nw);
        chk(nb == 7, "R5", "write busy cycles", nb, 7);
        chk(nw == WP_N, "R5", "write strobe cycles", nw, WP_N);
        chk(no == 0, "R5", "oe low during write", no, 0);
        access(1'b1, 17'h1FFFF, 8'h3C, nb, no, nw);
        access(1'b1, 17'h0ABCD, 8'h5A, nb, no, nw);

        // R3 / R7: read timing and turnaround
        access(1'b0, 17'h00000, 8'h00, nb, no, nw);
        chk(no == RD_N, "R3", "oe low cycles", no, RD_N);
        chk(nw == 0, "R3", "we low during read", nw, 0);
        chk(nb == RD_N + TA_N, "R7", "read busy cycles", nb, RD_N + TA_N);
        access(1'b0, 17'h1FFFF, 8'h00, nb, no, nw);
        access(1'b0, 17'h0ABCD, 8'h00, nb, no, nw);

        // R10: idle between accesses, address held
        @(negedge clk);
        chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n, "R10", "idle strobes",
            {mem_ce_n, mem_ce, mem_we_n, mem_oe_n}, 4'b1011);
        chk(mem_addr == 17'h0ABCD, "R10", "address held", mem_addr, 17'h0ABCD);

        // R7: write right after read (turnaround checked by the model), then read back
        access(1'b1, 17'h00100, 8'hC3, nb, no, nw);
        access(1'b0, 17'h00100, 8'h00, nb, no, nw);
        access(1'b0, 17'h00101, 8'h00, nb, no, nw);

        // R2: a request raised while busy is ignored
        while (!host_ready) @(negedge clk);
        shadow[5] = 8'h11;
        host_req = 1'b1; host_we = 1'b1; host_addr = 17'd5; host_wdata = 8'h11;
        @(negedge clk); host_req = 1'b0;
        @(negedge clk);
        chk(host_ready == 1'b0, "R2", "ready low during write", host_ready, 0);
        host_req = 1'b1; host_we = 1'b1; host_addr = 17'd6; host_wdata = 8'h77;
        @(negedge clk); host_req = 1'b0;
        access(1'b0, 17'd6, 8'h00, nb, no, nw);
        access(1'b0, 17'd5, 8'h00, nb, no, nw);

        // R8: standby requested during a read; the read completes first
        while (!host_ready) @(negedge clk);
        exp_q.push_back(8'hA5);
        host_req = 1'b1; host_we = 1'b0; host_addr = 17'h00000;
        @(negedge clk); host_req = 1'b0;
        @(negedge clk); stby_req = 1'b1;
        repeat (15) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "read finished before standby", exp_q.size(), 0);
        chk(mem_ce_n && !mem_ce, "R8", "selects inactive in standby", {mem_ce_n, mem_ce}, 2'b10);
        chk(host_ready == 1'b0, "R8", "ready low in standby", host_ready, 0);
        host_req = 1'b1; host_we = 1'b1; host_addr = 17'h00100; host_wdata = 8'hFF;
        repeat (3) @(negedge clk);
        host_req = 1'b0;
        chk(mem_we_n == 1'b1, "R8", "no write strobe in standby", mem_we_n, 1);

        // R9: recovery after standby ends
        stby_req = 1'b0;
        nb = 0;
        while (!host_ready) begin nb++; @(negedge clk); end
        chk(nb == RD_N + 1, "R9", "recovery edges", nb, RD_N + 1);
        access(1'b0, 17'h00100, 8'h00, nb, no, nw);

        repeat (15) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all reads returned", exp_q.size(), 0);
        chk(model_viol == 0, "R6", "memory model violations", model_viol, 0);
        finish_run();
    end

endmodule